// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches the eight input pins of one port for edge events and turns them into a single interrupt request for that port. Each pin has its own two-bit edge mode: no detection, rising edges only, falling edges only, or both edges. Every pin input first passes through a two-flop synchronizer. An edge detector then compares each synchronized sample with the sample taken one clock earlier. A detected event sets a sticky status bit for that pin. The port request is high while any status bit is set.

Software programs the modes and reads the status through a small register port. Reading the status register returns the pending bits and clears exactly those bits. An event that lands in the same cycle as the read stays pending for the next read. The returned bit pattern identifies the pin that caused the interrupt. A global sleep input is present, but detection takes no notice of it, so edges still raise the request while the rest of the system sleeps. Only edges are detected; a pin held at a steady level never sets status.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `rd_data` is 0, the mode register (address 0) reads 0 and the status register (address 1) reads 0.
- R2: A pin with mode 2'b01 sets its status bit on a 0-to-1 transition of its input and not on a 1-to-0 transition.
- R3: A pin with mode 2'b10 sets its status bit on a 1-to-0 transition and not on a 0-to-1 transition.
- R4: A pin with mode 2'b11 sets its status bit on either transition.
- R5: A pin with mode 2'b00 never sets its status bit.
- R6: Status bits are sticky, and `irq` is the OR of all status bits. It stays high with no read and falls only after a status read clears every bit.
- R7: A read of address 1 returns the status in `rd_data[7:0]` (bit n = pin n, upper bits 0) one clock after `rd_en`. It clears exactly the returned bits. An event detected in the read's cycle stays set.
- R8: The `sleep_req` input has no effect on detection, status or `irq`.
- R9: Writing a new mode while a pin is held steady creates no event.
- R10: A pin change driven between clock edges shows in status and `irq` after the third rising clock edge, and not after the second.
- R11: A write to address 0 loads the mode register (pin n's mode in bits [2n+1:2n]), and a read of address 0 returns it. Writes to address 1 change nothing.
- R12: Pins are independent: simultaneous events on several pins set exactly their own status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous port pin inputs |
| sleep_req | input | 1 | Global low-power indication, ignored by detection |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 status |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Port interrupt request |

## Verification
Several properties are checked on every cycle: status bits never drop without a read, a read never leaves a returned bit set unless a new event refilled it, and a new event always lands in status. The request falls only after a status read, a sleeping system still raises it, and each edge mode fires only at the matching input level. Other behaviour can only be shown by the bench's scenarios. That covers the exact three-edge latency, the absence of spurious events when a mode is rewritten over a steady pin, and the same-cycle race between a read and a new event. It also covers the mapping from pin to status bit seen through the register port.

// File: rtl/pin_evt_pkg.sv
// Package: shared types for the port pin edge interrupt controller.
// Assumes: two-bit per-pin mode field, register map of two words.
package pin_evt_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd1;

endpackage

// File: rtl/pin_evt_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Also flags when the last stage holds a real sample after reset.
// Assumes: STAGES >= 2, synchronous active-low reset.
module pin_evt_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] pin_sync,
    output logic             armed
);
    localparam int CNT_W = $clog2(STAGES + 1);

    logic [NPINS-1:0] stg [STAGES];
    logic [CNT_W-1:0] fill_cnt;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_async;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    // Count edges since reset until the chain is filled with real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  fill_cnt <= '0;
        else if (fill_cnt != CNT_W'(STAGES))         fill_cnt <= fill_cnt + 1'b1;
    end

    assign pin_sync = stg[STAGES-1];
    assign armed    = (fill_cnt == CNT_W'(STAGES));

    // R10: once armed the chain stays armed until reset.
    p_armed_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

endmodule

// File: rtl/pin_evt_edge.sv
// Module: single-pin edge detector with a selectable edge mode.
// Compares the synchronized sample with the previous clock's sample;
// the previous sample always tracks, so mode changes cannot fake an edge.
// Assumes: pin_sync already synchronized; armed marks valid samples.
module pin_evt_edge
    import pin_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_sync,
    input  logic       armed,
    input  edge_mode_e mode,
    output logic       event_o
);
    logic prev_q;
    logic prev_ok_q;
    logic rise;
    logic fall;

    // Keep last cycle's sample and whether it was valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            prev_ok_q <= 1'b0;
        end else begin
            prev_q    <= pin_sync;
            prev_ok_q <= armed;
        end
    end

    assign rise = pin_sync & ~prev_q;
    assign fall = ~pin_sync & prev_q;

    // Select the edges that count for this pin's mode.
    always_comb begin
        unique case (mode)
            EDGE_OFF:  event_o = 1'b0;
            EDGE_RISE: event_o = prev_ok_q & rise;
            EDGE_FALL: event_o = prev_ok_q & fall;
            EDGE_BOTH: event_o = prev_ok_q & (rise | fall);
            default:   event_o = 1'b0;
        endcase
    end

    // R5: disabled pin stays quiet.
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !event_o);
    // R2: rising events only with the pin now high.
    p_rise_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && mode == EDGE_RISE) |-> pin_sync);
    // R3: falling events only with the pin now low.
    p_fall_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && mode == EDGE_FALL) |-> !pin_sync);
    // R9: no event while the sample is unchanged from last cycle.
    p_steady_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sync == prev_q) |-> !event_o);

endmodule

// File: rtl/pin_evt_status.sv
// Module: sticky per-pin status with clear-on-read mask.
// A bit set by a new event in the clearing cycle wins over the clear.
// Assumes: clr_mask is a subset of the current status.
module pin_evt_status #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] ev,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status_q
);
    // Clear returned bits, then merge fresh events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | ev;
    end

    // R6: without a clear no bit drops.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R7: a cleared bit is gone unless a new event refilled it.
    p_clear_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((status_q & $past(clr_mask) & ~$past(ev)) == '0));
    // R12: each event lands in its own bit.
    p_event_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status_q & $past(ev)) == $past(ev)));

endmodule

// File: rtl/pin_evt_regs.sv
// Module: register port holding the mode word and muxing read data.
// A status read produces the clear mask for exactly the returned bits.
// Assumes: single-cycle strobes; read data registered.
module pin_evt_regs
    import pin_evt_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DATA_W = 2 * NPINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [NPINS-1:0]      status_q,
    output logic [2*NPINS-1:0]    mode_q,
    output logic [NPINS-1:0]      clr_mask,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int PAD_W = DATA_W - NPINS;

    logic [DATA_W-1:0] rd_mux;

    // Mode word updates only on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode_q <= '0;
        else if (wr_en && reg_addr == ADDR_MODE) mode_q <= wr_data[2*NPINS-1:0];
    end

    // Read multiplexer over the two defined words.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_MODE)      rd_mux = DATA_W'(mode_q);
        else if (reg_addr == ADDR_STAT) rd_mux = {{PAD_W{1'b0}}, status_q};
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign clr_mask = (rd_en && reg_addr == ADDR_STAT) ? status_q : '0;

    // R11: mode word stable unless written at its address.
    p_mode_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == ADDR_MODE) |=> $stable(mode_q));

endmodule

// File: rtl/pin_event_ctrl.sv
// Module: top of the port pin edge interrupt controller.
// Synchronizes the pins, runs one edge detector per pin, keeps sticky
// status and raises one request while any status bit is set.
// Assumes: synchronous active-low reset; sleep_req deliberately unused by logic.
module pin_event_ctrl
    import pin_evt_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 2 * NPINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      pin_in,
    input  logic                  sleep_req,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  irq
);
    logic [NPINS-1:0]   pin_sync;
    logic               armed;
    logic [NPINS-1:0]   ev;
    logic [NPINS-1:0]   status_q;
    logic [NPINS-1:0]   clr_mask;
    logic [2*NPINS-1:0] mode_q;

    pin_evt_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync),
        .armed     (armed)
    );

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            pin_evt_edge u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_sync (pin_sync[i]),
                .armed    (armed),
                .mode     (edge_mode_e'(mode_q[2*i +: 2])),
                .event_o  (ev[i])
            );
        end
    endgenerate

    pin_evt_status #(.NPINS(NPINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    pin_evt_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .status_q (status_q),
        .mode_q   (mode_q),
        .clr_mask (clr_mask),
        .rd_data  (rd_data)
    );

    assign irq = |status_q;

    // R6: request drops only right after a status read.
    p_irq_fall_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en && reg_addr == ADDR_STAT));
    // R8: events during sleep still raise the request.
    p_sleep_no_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && ev != '0) |=> irq);

endmodule

// File: tb/test_pin_event_ctrl.sv
`timescale 1ns/1ps
module test_pin_event_ctrl;
    localparam int NPINS  = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pin_in = '0;
    logic              sleep_req = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] d;

    // Vector: {pin[2:0], mode[1:0], from, to, expect_event}
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        {3'd0, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd0, 2'b01, 1'b1, 1'b0, 1'b0},
        {3'd1, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'd1, 2'b10, 1'b0, 1'b1, 1'b0},
        {3'd2, 2'b11, 1'b0, 1'b1, 1'b1},
        {3'd2, 2'b11, 1'b1, 1'b0, 1'b1},
        {3'd3, 2'b00, 1'b0, 1'b1, 1'b0},
        {3'd3, 2'b00, 1'b1, 1'b0, 1'b0},
        {3'd7, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd6, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'd5, 2'b11, 1'b1, 1'b0, 1'b1},
        {3'd4, 2'b00, 1'b0, 1'b1, 1'b0}
    };

    pin_event_ctrl i_pin_event_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .sleep_req (sleep_req),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] v);
        wr_en = 1'b1; reg_addr = a; wr_data = v;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] v);
        rd_en = 1'b1; reg_addr = a;
        tick(1);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 rd_data", rd_data, 0);
        rd(2'd0, d); chk("R1 mode", d, 0);
        rd(2'd1, d); chk("R1 status", d, 0);

        // R11: mode readback, and status address ignores writes
        wr(2'd0, 16'hA5C3);
        rd(2'd0, d); chk("R11 mode readback", d, 16'hA5C3);
        wr(2'd1, 16'h00FF);
        rd(2'd1, d); chk("R11 status write ignored", d, 0);
        chk("R11 irq after status write", irq, 0);
        wr(2'd0, 16'h0000);

        // Table walk: R2..R5 edge modes per pin
        for (int k = 0; k < NV; k++) begin
            logic [2:0] p;
            logic [1:0] m;
            p = VEC[k][7:5];
            m = VEC[k][4:3];
            wr(2'd0, 16'(m) << (2 * p));
            pin_in = '0;
            pin_in[p] = VEC[k][2];
            tick(4);
            rd(2'd1, d);
            tick(1);
            pin_in[p] = VEC[k][1];
            tick(3);
            chk({mode_req(m), " irq"}, irq, VEC[k][0]);
            rd(2'd1, d);
            chk({mode_req(m), " status"}, d, 16'(VEC[k][0]) << p);
            chk("R6 irq after clear", irq, 0);
        end

        // R10: latency of three rising edges
        pin_in = '0;
        wr(2'd0, 16'h0001);
        tick(4);
        rd(2'd1, d);
        pin_in[0] = 1'b1;
        tick(2);
        chk("R10 not yet after two edges", irq, 0);
        tick(1);
        chk("R10 set after third edge", irq, 1);

        // R6: sticky with no read
        tick(10);
        chk("R6 irq sticky", irq, 1);

        // R7: event landing in the read's cycle is kept
        wr(2'd0, 16'h0005);
        pin_in[1] = 1'b0;
        tick(4);
        pin_in[1] = 1'b1;
        tick(2);
        rd(2'd1, d);
        chk("R7 read returns older bit", d, 16'h0001);
        chk("R7 irq kept by new event", irq, 1);
        rd(2'd1, d);
        chk("R7 new bit survives", d, 16'h0002);
        chk("R7 irq cleared", irq, 0);

        // R9: mode rewrites over steady pins make no event
        pin_in = 8'h0F;
        wr(2'd0, 16'h0000);
        tick(4);
        rd(2'd1, d);
        wr(2'd0, 16'h5555);
        tick(2);
        wr(2'd0, 16'hFFFF);
        tick(2);
        wr(2'd0, 16'hAAAA);
        tick(4);
        chk("R9 irq after mode rewrites", irq, 0);
        rd(2'd1, d); chk("R9 status after mode rewrites", d, 0);

        // R8: sleep does not block detection
        sleep_req = 1'b1;
        wr(2'd0, 16'h0040);
        pin_in[3] = 1'b1;
        pin_in[3] = 1'b0;
        tick(1);
        pin_in[3] = 1'b1;
        tick(3);
        chk("R8 irq during sleep", irq, 1);
        rd(2'd1, d); chk("R8 status during sleep", d, 16'h0008);
        sleep_req = 1'b0;

        // R12: simultaneous events on all pins
        wr(2'd0, 16'hFFFF);
        pin_in = 8'h00;
        tick(4);
        rd(2'd1, d);
        pin_in = 8'hA5;
        tick(3);
        rd(2'd1, d); chk("R12 all-pin status", d, 16'h00A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule